// File: doc/BRIEF.md
# Byte-Steered Converter Result Read Port

This block sits between a data converter's result register and a host microprocessor bus that is 8 or 16 bits wide. It holds the 10-bit two's-complement result and its out-of-range flag, and it decides which output pins are driven during a host access. When the host uses a narrow bus it selects either the low byte or the high byte. It also drives a conversion status line that can float, and it returns an update enable to the conversion side so that a new result cannot tear a split read.

A 2-bit mode input selects one of three behaviours. In slow mode the host starts each conversion and may wait on the status line. In fast mode the converter runs continuously. A high-byte read then freezes the result register until the matching low-byte read ends. In DMA mode chip select and read are ignored, the outputs are always driven, and only the width and byte controls pick the driven pins. Tri-state behaviour is shown as data plus per-pin output enables, which a pad ring combines.

Top module: `adcbus_if`

## Requirements
- R1: Outside DMA mode, with cs_n and rd_n both low and bus_wide=1, all eleven dout_oe bits are 1 in the same cycle. Pin index 10 carries the out-of-range flag and pins 9..0 carry the result code.
- R2: With bus_wide=0 during an access, hb_sel=1 enables only pins 8, 9 and 10, and hb_sel=0 enables only pins 0 to 7.
- R3: Outside DMA mode, if cs_n or rd_n is high, every dout_oe bit is 0.
- R4: Outside DMA mode, busy_oe is 0 when cs_n and rd_n are both high, and 1 otherwise. In DMA mode it is always 1.
- R5: busy equals the inverse of conv_active in slow mode and is 0 in fast and DMA modes.
- R6: After reset dout is 0 and upd_en is 1. A conv_done pulse while upd_en=1 makes dout equal {res_ovr, res_code} from the following cycle. dout does not change without such a pulse.
- R7: A read completes at the first clock edge at which rd_n is high, following an edge at which cs_n and rd_n were both low. The width and byte selection sampled during the access apply to that read.
- R8: In fast mode (mode_sel=1), a completed byte-mode high-byte read sets upd_en to 0. Every conv_done result that arrives while upd_en is 0 is discarded.
- R9: In fast mode, a completed low-byte read or a completed full-width read sets upd_en back to 1. A low-byte read made first therefore does not stop the next high-byte read from locking.
- R10: In slow mode (mode_sel=0, or the reserved code 3), completed reads never change upd_en, so the bytes may be read in either order.
- R11: In DMA mode (mode_sel=2), cs_n and rd_n have no effect. dout_oe follows only bus_wide and hb_sel, and each conv_done is captured.
- R12: If mode_sel is not fast at a clock edge, upd_en is 1 after that edge.
- R13: In slow mode with cs_n and rd_n held low, dout refreshes at every conv_done while the enables stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_wide | input | 1 | 1 = all pins together, 0 = byte mode |
| hb_sel | input | 1 | Byte mode: 1 = high byte, 0 = low byte |
| mode_sel | input | 2 | 0 slow, 1 fast, 2 DMA, 3 treated as slow |
| conv_active | input | 1 | Conversion in progress |
| res_code | input | 10 | New conversion result |
| res_ovr | input | 1 | Out-of-range flag of the new result |
| conv_done | input | 1 | End-of-conversion pulse, one cycle |
| dout | output | 11 | Held result: bit 10 flag, bits 9..0 code |
| dout_oe | output | 11 | Per-pin output enable |
| busy | output | 1 | Status value, 1 = conversion complete |
| busy_oe | output | 1 | Status line output enable |
| upd_en | output | 1 | Result register may be updated |

## Verification
The output enables and the status line are combinational from the pins and the mode. They are sampled one time step after each input change in the same low clock phase. A result loads at the clock edge where conv_done is high and is compared at the next falling edge. A read completes at the edge where rd_n is first seen high, so the effect on upd_en is checked at the falling edge after that completion edge. A capture that depends on the lock is pulsed only after that check.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;

  typedef enum logic [1:0] {
    MODE_SLOW = 2'd0,
    MODE_FAST = 2'd1,
    MODE_DMA  = 2'd2,
    MODE_RSVD = 2'd3
  } bus_mode_e;

  function automatic logic mode_is_fast(input logic [1:0] m);
    return m == MODE_FAST;
  endfunction

  function automatic logic mode_is_dma(input logic [1:0] m);
    return m == MODE_DMA;
  endfunction

  // slow behaviour covers the reserved code as well
  function automatic logic mode_is_slow(input logic [1:0] m);
    return !mode_is_fast(m) && !mode_is_dma(m);
  endfunction

endpackage

// File: rtl/adcbus_access_det.sv
module adcbus_access_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic bus_wide,
  input  logic hb_sel,
  output logic read_done,
  output logic done_wide,
  output logic done_high
);

  logic acc_q;
  logic wide_q;
  logic high_q;
  logic host_sel;

  assign host_sel = ~cs_n & ~rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      wide_q <= 1'b0;
      high_q <= 1'b0;
    end else begin
      acc_q <= host_sel;
      if (host_sel) begin
        wide_q <= bus_wide;
        high_q <= hb_sel;
      end
    end
  end

  // completion is the end of the access: strobe seen high after an access cycle
  assign read_done = acc_q & rd_n;
  assign done_wide = wide_q;
  assign done_high = high_q;

  // R7
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |=> !read_done);

endmodule

// File: rtl/adcbus_lock_ctl.sv
module adcbus_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_fast,
  input  logic read_done,
  input  logic done_wide,
  input  logic done_high,
  output logic lock
);

  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (!mode_fast) begin
      lock_q <= 1'b0;
    end else if (read_done) begin
      lock_q <= done_wide ? 1'b0 : done_high;
    end
  end

  assign lock = lock_q;

  // R8
  high_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fast && read_done && !done_wide && done_high) |=> lock);

  // R9
  low_read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fast && read_done && (done_wide || !done_high)) |=> !lock);

  // R12
  fast_only_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_fast |=> !lock);

endmodule

// File: rtl/adcbus_out_latch.sv
module adcbus_out_latch #(
  parameter int OUT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] din,
  output logic [OUT_W-1:0] q
);

  logic [OUT_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (load) q_r <= din;
  end

  assign q = q_r;

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(din));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/adcbus_if.sv
module adcbus_if #(
  parameter int CODE_W = 10,
  parameter int LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              bus_wide,
  input  logic              hb_sel,
  input  logic [1:0]        mode_sel,
  input  logic              conv_active,
  input  logic [CODE_W-1:0] res_code,
  input  logic              res_ovr,
  input  logic              conv_done,
  output logic [CODE_W:0]   dout,
  output logic [CODE_W:0]   dout_oe,
  output logic              busy,
  output logic              busy_oe,
  output logic              upd_en
);
  import adcbus_pkg::*;

  localparam int OUT_W = CODE_W + 1;
  localparam logic [OUT_W-1:0] LOW_MASK  = OUT_W'((1 << LOW_W) - 1);
  localparam logic [OUT_W-1:0] HIGH_MASK = ~LOW_MASK;

  logic is_fast;
  logic is_dma;
  logic is_slow;
  logic host_sel;
  logic drive_en;
  logic read_done;
  logic done_wide;
  logic done_high;
  logic lock;
  logic load;

  assign is_fast  = mode_is_fast(mode_sel);
  assign is_dma   = mode_is_dma(mode_sel);
  assign is_slow  = mode_is_slow(mode_sel);
  assign host_sel = ~cs_n & ~rd_n;
  assign drive_en = is_dma | host_sel;

  adcbus_access_det u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .bus_wide (bus_wide),
    .hb_sel   (hb_sel),
    .read_done(read_done),
    .done_wide(done_wide),
    .done_high(done_high)
  );

  adcbus_lock_ctl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_fast(is_fast),
    .read_done(read_done),
    .done_wide(done_wide),
    .done_high(done_high),
    .lock     (lock)
  );

  assign upd_en = ~lock;
  assign load   = conv_done & upd_en;

  adcbus_out_latch #(.OUT_W(OUT_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .din  ({res_ovr, res_code}),
    .q    (dout)
  );

  // per-pin enable: each pin belongs to the high or low byte group
  for (genvar i = 0; i < OUT_W; i++) begin : g_pin
    localparam logic IN_HIGH = (i >= LOW_W);
    assign dout_oe[i] = drive_en & (bus_wide | (hb_sel == IN_HIGH));
  end

  assign busy_oe = is_dma | ~cs_n | ~rd_n;
  assign busy    = is_slow & ~conv_active;

  // R1
  wide_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_dma && !cs_n && !rd_n && bus_wide) |-> (&dout_oe));

  // R2
  byte_groups_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wide |-> !((|(dout_oe & LOW_MASK)) && (|(dout_oe & HIGH_MASK))));

  // R3
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_dma && (cs_n || rd_n)) |-> (dout_oe == '0));

  // R4
  busy_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_dma && cs_n && rd_n) |-> !busy_oe);

  // R5
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_slow |-> !busy);

  // R8
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !upd_en) |=> $stable(dout));

  // R11
  dma_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_dma |-> (dout_oe != '0));

endmodule

// File: tb/sim_adcbus_if.sv
module sim_adcbus_if;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        bus_wide = 1'b1;
  logic        hb_sel = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        conv_active = 1'b0;
  logic [9:0]  res_code = '0;
  logic        res_ovr = 1'b0;
  logic        conv_done = 1'b0;
  logic [10:0] dout;
  logic [10:0] dout_oe;
  logic        busy;
  logic        busy_oe;
  logic        upd_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcbus_if u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .bus_wide(bus_wide),
    .hb_sel(hb_sel), .mode_sel(mode_sel), .conv_active(conv_active),
    .res_code(res_code), .res_ovr(res_ovr), .conv_done(conv_done),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .busy_oe(busy_oe), .upd_en(upd_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [10:0] exp_oe(input int m, input bit c, input bit r,
                                         input bit w, input bit h);
    int lowm = (1 << 8) - 1;
    int allm = (1 << 11) - 1;
    if (!(m == 2 || (!c && !r))) return 11'd0;
    if (w) return 11'(allm);
    return h ? 11'(allm - lowm) : 11'(lowm);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; conv_done = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one access cycle, then strobe high; returns at the negedge after completion edge
  task automatic do_read(input bit wide, input bit high);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; bus_wide = wide; hb_sel = high;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_done(input logic [9:0] code, input bit ovr);
    @(negedge clk);
    res_code = code; res_ovr = ovr; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R6 reset state
    chk("R6 reset dout", dout, 0);
    chk("R6 reset upd_en", upd_en, 1);
    chk("R3 reset oe", dout_oe, 0);
    chk("R4 reset busy_oe", busy_oe, 0);

    // R1 R2 R3 R4 R5 R11: sweep of modes and control pins
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 32; v++) begin
        @(negedge clk);
        mode_sel = 2'(m);
        cs_n = v[0]; rd_n = v[1]; bus_wide = v[2]; hb_sel = v[3]; conv_active = v[4];
        #1;
        chk("R1 R2 R3 R11 dout_oe", dout_oe, exp_oe(m, v[0], v[1], v[2], v[3]));
        chk("R4 busy_oe", busy_oe, (m == 2 || !v[0] || !v[1]) ? 1 : 0);
        chk("R5 busy", busy, ((m == 0 || m == 3) && !v[4]) ? 1 : 0);
      end
    end
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; conv_active = 1'b0; mode_sel = 2'd0;
    do_reset();

    // R6 capture of several codes in slow mode
    for (int k = 0; k < 8; k++) begin
      logic [9:0] c;
      c = 10'((k * 311 + 1) % 1024);
      pulse_done(c, k[0]);
      chk("R6 capture", dout, {k[0], c});
    end

    // R10 slow mode: high then low, low then high never lock
    do_read(1'b0, 1'b1);
    chk("R10 slow high read", upd_en, 1);
    pulse_done(10'h155, 1'b0);
    chk("R10 slow capture after high read", dout, 11'h155);
    do_read(1'b0, 1'b0);
    do_read(1'b0, 1'b1);
    chk("R10 slow low-high order", upd_en, 1);

    // R8 R9 fast mode lock
    @(negedge clk); mode_sel = 2'd1;
    do_read(1'b0, 1'b1);
    chk("R8 fast lock set", upd_en, 0);
    pulse_done(10'h2AA, 1'b1);
    chk("R8 result discarded", dout, 11'h155);
    do_read(1'b0, 1'b0);
    chk("R9 low read unlocks", upd_en, 1);
    pulse_done(10'h0F0, 1'b0);
    chk("R9 capture after unlock", dout, 11'h0F0);
    // low first then high: next result lost
    do_read(1'b0, 1'b0);
    chk("R9 low first no lock", upd_en, 1);
    do_read(1'b0, 1'b1);
    chk("R9 high after low locks", upd_en, 0);
    pulse_done(10'h3FF, 1'b1);
    chk("R8 lost after misordered read", dout, 11'h0F0);
    do_read(1'b1, 1'b0);
    chk("R9 wide read unlocks", upd_en, 1);

    // R7 access without strobe release, cs high: no completion while rd low
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; bus_wide = 1'b0; hb_sel = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R7 no completion while rd low", upd_en, 1);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R7 strobe release after cs gone", upd_en, 1);

    // R12 leaving fast clears lock
    do_read(1'b0, 1'b1);
    chk("R8 relock", upd_en, 0);
    mode_sel = 2'd0;
    @(negedge clk);
    chk("R12 mode change unlocks", upd_en, 1);

    // R11 DMA: pins ignored, capture continuous
    mode_sel = 2'd2; cs_n = 1'b1; rd_n = 1'b1; bus_wide = 1'b0; hb_sel = 1'b1;
    #1;
    chk("R11 dma high byte enable", dout_oe, 11'h700);
    do_read(1'b0, 1'b1);
    chk("R11 dma no lock", upd_en, 1);
    pulse_done(10'h201, 1'b0);
    chk("R11 dma capture", dout, 11'h201);

    // R13 slow mode with strobe held low
    @(negedge clk);
    mode_sel = 2'd0; cs_n = 1'b0; rd_n = 1'b0; bus_wide = 1'b1;
    pulse_done(10'h011, 1'b0);
    chk("R13 refresh 1", dout, 11'h011);
    chk("R13 oe held", dout_oe, 11'h7FF);
    pulse_done(10'h3A5, 1'b1);
    chk("R13 refresh 2", dout, 11'h7A5);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    summary();
  end

endmodule